// File: doc/BRIEF.md
# Fragment Alpha, Stencil and Depth Test Unit

This block decides, for each incoming fragment, whether it survives the per-pixel tests that sit just before colour blending. It takes the fragment alpha and depth, together with the depth and 8-bit stencil value already held in the buffer for that pixel. It then runs three tests in a fixed order: alpha first, then stencil, then depth. The outcome is a pass/kill decision. The unit also produces the stencil value to write back (already merged through the write mask), a stencil write strobe, a depth write strobe and four per-channel colour write enables.

Four 32-bit configuration words program the tests. Each word holds an enable, a comparison function and reference or mask fields. The stencil test applies an input mask to both sides of its comparison. Three independent actions cover the three outcomes: stencil failed, stencil passed but depth failed, and both passed. Each action comes from an eight-entry set that includes saturating and wrapping counters. The unit accepts one fragment per clock, qualified by a valid strobe, and produces its results two cycles later. Buffer access, blending and pixel format conversion are handled by neighbouring blocks.

Top module: `ost_fragment_test`

## Requirements
- R1: Comparison codes are 0 never, 1 always, 2 equal, 3 not-equal, 4 less, 5 less-or-equal, 6 greater, 7 greater-or-equal, with the fragment-side value on the left. The alpha test uses `cfg_alpha` bit 0 as enable, bits 6:4 as function and bits 15:8 as reference, comparing `frag_alpha` against that reference. A disabled alpha test passes.
- R2: A fragment failing the alpha test is killed: `out_pass`, `out_stencil_we`, `out_depth_we` and `out_color_we` are all 0.
- R3: The stencil test compares (reference & input mask) against (`buf_stencil` & input mask). In `cfg_stencil`, enable is bit 0, function is bits 6:4, reference is bits 23:16 and input mask is bits 31:24. A failing stencil test kills the fragment.
- R4: With stencil enable clear, the stencil test passes and `out_stencil_we` is 0.
- R5: When the alpha test passes and the stencil test is enabled, `out_stencil_we` is 1. The action is chosen from `cfg_stencil_op`: bits 2:0 on stencil fail, bits 6:4 on depth fail, bits 10:8 when both pass.
- R6: Action codes on the stored value s are: 0 keep s, 1 zero, 2 the stencil reference, 3 s+1 clamped at 255, 4 s-1 clamped at 0, 5 bitwise inverse of s, 6 s+1 modulo 256, 7 s-1 modulo 256.
- R7: `out_stencil` equals (action result & write mask) | (`buf_stencil` & ~write mask), with the write mask taken from `cfg_stencil` bits 15:8.
- R8: The depth test compares `frag_depth` against `buf_depth`. In `cfg_depth_mask`, enable is bit 0 and function is bits 6:4. A disabled depth test passes, and a failing one kills the fragment.
- R9: `out_depth_we` is 1 exactly when the fragment passes all three tests and `cfg_depth_mask` bit 12 is set.
- R10: `out_color_we` equals `cfg_depth_mask` bits 11:8 (bit 8 to `out_color_we[0]` red, then green, blue, alpha) for a passing fragment, and 0 otherwise.
- R11: One fragment is accepted per cycle. Results appear with `out_valid` exactly two cycles after `in_valid`. While `out_valid` is 0, `out_pass`, `out_stencil_we`, `out_depth_we` and `out_color_we` are 0.
- R12: While reset is asserted, `out_valid`, `out_pass` and all write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fragment present on the inputs |
| frag_depth | input | DEPTH_W | Fragment depth |
| buf_depth | input | DEPTH_W | Depth stored for the pixel |
| buf_stencil | input | 8 | Stencil value stored for the pixel |
| frag_alpha | input | 8 | Fragment alpha |
| cfg_alpha | input | 32 | Alpha test word |
| cfg_stencil | input | 32 | Stencil test word |
| cfg_stencil_op | input | 32 | Stencil action word |
| cfg_depth_mask | input | 32 | Depth test and write-enable word |
| out_valid | output | 1 | Result present |
| out_pass | output | 1 | Fragment survives all tests |
| out_stencil_we | output | 1 | Stencil write strobe |
| out_stencil | output | 8 | Merged stencil value to write |
| out_depth_we | output | 1 | Depth write strobe |
| out_color_we | output | 4 | Colour channel write enables, bit 0 red |

## Verification
The hardest outcome to reach is the depth-fail action applied at the counter limits. It needs a fragment that clears alpha and stencil yet loses the depth comparison, while the stored stencil sits at 0 or 255 so that the saturating and wrapping codes differ. The stimulus forces each of the three action paths in turn. For the stencil-fail path it uses a stencil function of "never". For the depth-fail path it uses "always" with a depth function of "never". For the both-pass path it uses "always" with depth disabled. Every action code is swept across stored values at both ends and mid-range, with fragments streamed back to back and idle gaps mixed in.

// File: rtl/ost_pkg.sv
package ost_pkg;

  localparam int STEN_W  = 8;
  localparam int ALPHA_W = 8;
  localparam int CWE_W   = 4;
  localparam int FN_W    = 3;
  localparam int NUM_ACT = 3;

  // field positions inside the configuration words
  localparam int F_EN       = 0;
  localparam int F_FN_LO    = 4;
  localparam int A_REF_LO   = 8;
  localparam int S_WM_LO    = 8;
  localparam int S_REF_LO   = 16;
  localparam int S_IM_LO    = 24;
  localparam int OP_SF_LO   = 0;
  localparam int OP_ZF_LO   = 4;
  localparam int OP_OK_LO   = 8;
  localparam int DM_CWE_LO  = 8;
  localparam int DM_DWE     = 12;

  // index of the action path
  localparam int SEL_SFAIL = 0;
  localparam int SEL_ZFAIL = 1;
  localparam int SEL_PASS  = 2;

  typedef enum logic [FN_W-1:0] {
    CMP_NEVER  = 3'd0,
    CMP_ALWAYS = 3'd1,
    CMP_EQ     = 3'd2,
    CMP_NE     = 3'd3,
    CMP_LT     = 3'd4,
    CMP_LE     = 3'd5,
    CMP_GT     = 3'd6,
    CMP_GE     = 3'd7
  } cmp_fn_e;

  typedef enum logic [2:0] {
    ACT_KEEP     = 3'd0,
    ACT_ZERO     = 3'd1,
    ACT_REPLACE  = 3'd2,
    ACT_INC_SAT  = 3'd3,
    ACT_DEC_SAT  = 3'd4,
    ACT_INVERT   = 3'd5,
    ACT_INC_WRAP = 3'd6,
    ACT_DEC_WRAP = 3'd7
  } sten_act_e;

  typedef struct packed {
    logic              alpha_ok;
    logic              sten_ok;
    logic              depth_ok;
    logic              sten_en;
    logic [STEN_W-1:0] stored;
    logic [STEN_W-1:0] ref_v;
    logic [STEN_W-1:0] wmask;
    logic [2:0]        act_sfail;
    logic [2:0]        act_zfail;
    logic [2:0]        act_pass;
    logic              dwe_en;
    logic [CWE_W-1:0]  cwe;
  } stage1_t;

endpackage

// File: rtl/ost_cmp.sv
module ost_cmp
  import ost_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [FN_W-1:0] func,
  input  logic [W-1:0]    lhs,
  input  logic [W-1:0]    rhs,
  output logic            hit
);

  always_comb begin
    case (cmp_fn_e'(func))
      CMP_NEVER:  hit = 1'b0;
      CMP_ALWAYS: hit = 1'b1;
      CMP_EQ:     hit = (lhs == rhs);
      CMP_NE:     hit = (lhs != rhs);
      CMP_LT:     hit = (lhs <  rhs);
      CMP_LE:     hit = (lhs <= rhs);
      CMP_GT:     hit = (lhs >  rhs);
      CMP_GE:     hit = (lhs >= rhs);
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ost_sten_act.sv
module ost_sten_act
  import ost_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   act,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] ref_v,
  output logic [W-1:0] nxt
);

  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    case (sten_act_e'(act))
      ACT_KEEP:     nxt = cur;
      ACT_ZERO:     nxt = '0;
      ACT_REPLACE:  nxt = ref_v;
      ACT_INC_SAT:  nxt = (cur == TOP) ? cur : cur + ONE;
      ACT_DEC_SAT:  nxt = (cur == '0)  ? cur : cur - ONE;
      ACT_INVERT:   nxt = ~cur;
      ACT_INC_WRAP: nxt = cur + ONE;
      ACT_DEC_WRAP: nxt = cur - ONE;
      default:      nxt = cur;
    endcase
  end

endmodule

// File: rtl/ost_fragment_test.sv
module ost_fragment_test
  import ost_pkg::*;
#(
  parameter int DEPTH_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DEPTH_W-1:0] frag_depth,
  input  logic [DEPTH_W-1:0] buf_depth,
  input  logic [STEN_W-1:0]  buf_stencil,
  input  logic [ALPHA_W-1:0] frag_alpha,
  input  logic [31:0]        cfg_alpha,
  input  logic [31:0]        cfg_stencil,
  input  logic [31:0]        cfg_stencil_op,
  input  logic [31:0]        cfg_depth_mask,
  output logic               out_valid,
  output logic               out_pass,
  output logic               out_stencil_we,
  output logic [STEN_W-1:0]  out_stencil,
  output logic               out_depth_we,
  output logic [CWE_W-1:0]   out_color_we
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  // ---------------- stage 1: comparisons ----------------
  logic              alpha_hit, sten_hit, depth_hit;
  logic [STEN_W-1:0] sten_im;

  assign sten_im = cfg_stencil[S_IM_LO +: STEN_W];

  ost_cmp #(.W(ALPHA_W)) u_cmp_alpha (
    .func (cfg_alpha[F_FN_LO +: FN_W]),
    .lhs  (frag_alpha),
    .rhs  (cfg_alpha[A_REF_LO +: ALPHA_W]),
    .hit  (alpha_hit)
  );

  ost_cmp #(.W(STEN_W)) u_cmp_sten (
    .func (cfg_stencil[F_FN_LO +: FN_W]),
    .lhs  (cfg_stencil[S_REF_LO +: STEN_W] & sten_im),
    .rhs  (buf_stencil & sten_im),
    .hit  (sten_hit)
  );

  ost_cmp #(.W(DEPTH_W)) u_cmp_depth (
    .func (cfg_depth_mask[F_FN_LO +: FN_W]),
    .lhs  (frag_depth),
    .rhs  (buf_depth),
    .hit  (depth_hit)
  );

  stage1_t s1_d, s1_q;
  logic    s1_v_q;

  always_comb begin
    s1_d.alpha_ok  = !cfg_alpha[F_EN] || alpha_hit;
    s1_d.sten_ok   = !cfg_stencil[F_EN] || sten_hit;
    s1_d.depth_ok  = !cfg_depth_mask[F_EN] || depth_hit;
    s1_d.sten_en   = cfg_stencil[F_EN];
    s1_d.stored    = buf_stencil;
    s1_d.ref_v     = cfg_stencil[S_REF_LO +: STEN_W];
    s1_d.wmask     = cfg_stencil[S_WM_LO +: STEN_W];
    s1_d.act_sfail = cfg_stencil_op[OP_SF_LO +: 3];
    s1_d.act_zfail = cfg_stencil_op[OP_ZF_LO +: 3];
    s1_d.act_pass  = cfg_stencil_op[OP_OK_LO +: 3];
    s1_d.dwe_en    = cfg_depth_mask[DM_DWE];
    s1_d.cwe       = cfg_depth_mask[DM_CWE_LO +: CWE_W];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) s1_v_q <= 1'b0;
    else             s1_v_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) s1_q <= s1_d;
  end

  // ---------------- stage 2: actions and enables ----------------
  logic [2:0]        act_code [NUM_ACT];
  logic [STEN_W-1:0] act_res  [NUM_ACT];

  assign act_code[SEL_SFAIL] = s1_q.act_sfail;
  assign act_code[SEL_ZFAIL] = s1_q.act_zfail;
  assign act_code[SEL_PASS]  = s1_q.act_pass;

  for (genvar k = 0; k < NUM_ACT; k++) begin : g_act
    ost_sten_act #(.W(STEN_W)) u_act (
      .act   (act_code[k]),
      .cur   (s1_q.stored),
      .ref_v (s1_q.ref_v),
      .nxt   (act_res[k])
    );
  end

  logic [STEN_W-1:0] chosen;
  logic              pass_n, swe_n, dwe_n;
  logic [STEN_W-1:0] sval_n;
  logic [CWE_W-1:0]  cwe_n;

  always_comb begin
    if (!s1_q.sten_ok)       chosen = act_res[SEL_SFAIL];
    else if (!s1_q.depth_ok) chosen = act_res[SEL_ZFAIL];
    else                     chosen = act_res[SEL_PASS];
    sval_n = (chosen & s1_q.wmask) | (s1_q.stored & ~s1_q.wmask);
    pass_n = s1_v_q && s1_q.alpha_ok && s1_q.sten_ok && s1_q.depth_ok;
    swe_n  = s1_v_q && s1_q.alpha_ok && s1_q.sten_en;
    dwe_n  = pass_n && s1_q.dwe_en;
    cwe_n  = pass_n ? s1_q.cwe : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid      <= 1'b0;
      out_pass       <= 1'b0;
      out_stencil_we <= 1'b0;
      out_depth_we   <= 1'b0;
      out_color_we   <= '0;
    end else begin
      out_valid      <= s1_v_q;
      out_pass       <= pass_n;
      out_stencil_we <= swe_n;
      out_depth_we   <= dwe_n;
      out_color_we   <= cwe_n;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_v_q) out_stencil <= sval_n;
  end

endmodule

// File: rtl/ost_fragment_test_chk.sv
module ost_fragment_test_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] buf_stencil,
  input logic       sten_en,
  input logic [7:0] sten_wm,
  input logic       dwe_cfg,
  input logic       out_valid,
  input logic       out_pass,
  input logic       out_stencil_we,
  input logic [7:0] out_stencil,
  input logic       out_depth_we,
  input logic [3:0] out_color_we
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_pass && !out_stencil_we && !out_depth_we && out_color_we == 4'h0)); // R11

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid); // R11

  AST_KILL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_pass) |-> (!out_depth_we && out_color_we == 4'h0)); // R10

  AST_STEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_stencil_we |-> (((out_stencil ^ $past(buf_stencil, 2)) & ~$past(sten_wm, 2)) == 8'h00)); // R7

  AST_STEN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    out_stencil_we |-> $past(sten_en, 2)); // R4

  AST_DEPTH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    out_depth_we |-> ($past(dwe_cfg, 2) && out_pass)); // R9

endmodule

bind ost_fragment_test ost_fragment_test_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .in_valid       (in_valid),
  .buf_stencil    (buf_stencil),
  .sten_en        (cfg_stencil[0]),
  .sten_wm        (cfg_stencil[15:8]),
  .dwe_cfg        (cfg_depth_mask[12]),
  .out_valid      (out_valid),
  .out_pass       (out_pass),
  .out_stencil_we (out_stencil_we),
  .out_stencil    (out_stencil),
  .out_depth_we   (out_depth_we),
  .out_color_we   (out_color_we)
);

// File: tb/test_ost_fragment_test.sv
module test_ost_fragment_test;

  localparam int DW = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, in_valid;
  logic [DW-1:0] frag_depth, buf_depth;
  logic [7:0]    buf_stencil, frag_alpha;
  logic [31:0]   cfg_alpha, cfg_stencil, cfg_stencil_op, cfg_depth_mask;
  logic          out_valid, out_pass, out_stencil_we, out_depth_we;
  logic [7:0]    out_stencil;
  logic [3:0]    out_color_we;

  ost_fragment_test #(.DEPTH_W(DW)) i_ost_fragment_test (
    .clk, .rst_n, .in_valid, .frag_depth, .buf_depth, .buf_stencil, .frag_alpha,
    .cfg_alpha, .cfg_stencil, .cfg_stencil_op, .cfg_depth_mask,
    .out_valid, .out_pass, .out_stencil_we, .out_stencil, .out_depth_we, .out_color_we
  );

  int n_chk = 0, n_fail = 0;
  logic [14:0] exp_q [0:1023];
  string       tag_q [0:1023];
  int          wr = 0, rd = 0;
  logic        mon_on = 1'b0, prev_iv = 1'b0;

  // staged stimulus
  logic [31:0]   ca, cs, co, cd;
  logic [7:0]    fa, bs;
  logic [DW-1:0] fd, bd;

  function automatic logic cmpf(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return a == b;
      3'd3: return a != b;
      3'd4: return a < b;
      3'd5: return a <= b;
      3'd6: return a > b;
      default: return a >= b;
    endcase
  endfunction

  function automatic logic [7:0] actf(input logic [2:0] c, input logic [7:0] s, input logic [7:0] r);
    int v;
    case (c)
      3'd0: v = s;
      3'd1: v = 0;
      3'd2: v = r;
      3'd3: v = (s == 255) ? 255 : s + 1;
      3'd4: v = (s == 0) ? 0 : s - 1;
      3'd5: v = 255 - s;
      3'd6: v = (s + 1) % 256;
      default: v = (s + 255) % 256;
    endcase
    return v[7:0];
  endfunction

  function automatic logic [14:0] model();
    logic a_ok, s_ok, d_ok, pass, swe, dwe;
    logic [7:0] im, nv, sv;
    logic [2:0] code;
    logic [3:0] cwe;
    a_ok = !ca[0] || cmpf(ca[6:4], {24'h0, fa}, {24'h0, ca[15:8]});
    im   = cs[31:24];
    s_ok = !cs[0] || cmpf(cs[6:4], {24'h0, cs[23:16] & im}, {24'h0, bs & im});
    d_ok = !cd[0] || cmpf(cd[6:4], {8'h0, fd}, {8'h0, bd});
    pass = a_ok && s_ok && d_ok;
    swe  = a_ok && cs[0];
    code = !s_ok ? co[2:0] : (!d_ok ? co[6:4] : co[10:8]);
    nv   = actf(code, bs, cs[23:16]);
    sv   = (nv & cs[15:8]) | (bs & ~cs[15:8]);
    dwe  = pass && cd[12];
    cwe  = pass ? cd[11:8] : 4'h0;
    return {pass, swe, dwe, cwe, swe ? sv : 8'h00};
  endfunction

  task automatic send(input string tag);
    if (wr % 7 == 6) begin
      @(negedge clk); #1;
      in_valid = 1'b0;
    end
    @(negedge clk); #1;
    cfg_alpha = ca; cfg_stencil = cs; cfg_stencil_op = co; cfg_depth_mask = cd;
    frag_alpha = fa; buf_stencil = bs; frag_depth = fd; buf_depth = bd;
    in_valid = 1'b1;
    exp_q[wr] = model();
    tag_q[wr] = tag;
    wr++;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      n_chk++;
      if (out_valid !== prev_iv) begin
        n_fail++;
        $display("FAIL R11 out_valid actual %b expected %b", out_valid, prev_iv);
      end
      if (out_valid) begin
        logic [14:0] act;
        act = {out_pass, out_stencil_we, out_depth_we, out_color_we,
               out_stencil_we ? out_stencil : 8'h00};
        n_chk++;
        if (rd >= wr) begin
          n_fail++;
          $display("FAIL R11 unexpected result actual %h expected none", act);
        end else begin
          if (act !== exp_q[rd]) begin
            n_fail++;
            $display("FAIL %s fragment %0d {pass,swe,dwe,cwe,sten} actual %h expected %h",
                     tag_q[rd], rd, act, exp_q[rd]);
          end
          rd++;
        end
      end else begin
        n_chk++;
        if (out_pass || out_stencil_we || out_depth_we || out_color_we != 4'h0) begin
          n_fail++;
          $display("FAIL R11 idle outputs actual %b%b%b%h expected 0000",
                   out_pass, out_stencil_we, out_depth_we, out_color_we);
        end
      end
      prev_iv = in_valid;
    end
  end

  initial begin
    #(200000 * 4);
    n_fail++;
    n_chk++;
    $display("FAIL R11 watchdog expired actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [7:0]    alph [5] = '{8'h00, 8'h7f, 8'h80, 8'h81, 8'hff};
  logic [7:0]    sten3 [3] = '{8'h10, 8'h20, 8'h30};
  logic [7:0]    imsk [3] = '{8'hff, 8'hf0, 8'h0f};
  logic [7:0]    edge5 [5] = '{8'h00, 8'h01, 8'h7f, 8'hfe, 8'hff};
  logic [7:0]    wml [4] = '{8'h00, 8'hff, 8'ha5, 8'h0f};
  logic [7:0]    bsl [5] = '{8'h00, 8'hff, 8'ha5, 8'h5a, 8'h33};
  logic [DW-1:0] fdl [5] = '{24'h000100, 24'h000200, 24'h000300, 24'h000000, 24'hffffff};
  logic [DW-1:0] bdl [5] = '{24'h000200, 24'h000200, 24'h000200, 24'hffffff, 24'h000000};

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    frag_depth = '0; buf_depth = '0; buf_stencil = '0; frag_alpha = '0;
    cfg_alpha = '0; cfg_stencil = '0; cfg_stencil_op = '0; cfg_depth_mask = '0;
    repeat (4) @(negedge clk);
    n_chk++;
    if (out_valid || out_pass || out_stencil_we || out_depth_we || out_color_we != 4'h0) begin
      n_fail++;
      $display("FAIL R12 reset outputs actual %b%b%b%b%h expected 00000",
               out_valid, out_pass, out_stencil_we, out_depth_we, out_color_we);
    end
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    fa = 8'h00; bs = 8'h00; fd = '0; bd = '0;

    // alpha test sweep (R1, R2)
    cs = '0; co = '0; cd = 32'h0000_1F00;
    for (int en = 0; en < 2; en++)
      for (int f = 0; f < 8; f++)
        for (int i = 0; i < 5; i++) begin
          ca = {16'h0, 8'h80, 1'b0, 3'(f), 3'b000, 1'(en)};
          fa = alph[i];
          send("R1,R2");
        end

    // stencil compare with input masks (R3, R4, R5)
    ca = '0; co = 32'h0000_0321; cd = 32'h0000_1F00;
    for (int en = 0; en < 2; en++)
      for (int f = 0; f < 8; f++)
        for (int m = 0; m < 3; m++)
          for (int i = 0; i < 3; i++) begin
            cs = {imsk[m], 8'h20, 8'hff, 1'b0, 3'(f), 3'b000, 1'(en)};
            bs = sten3[i];
            send("R3,R4,R5");
          end

    // every action on every path at the counter limits (R5, R6)
    ca = '0;
    for (int a = 0; a < 8; a++)
      for (int p = 0; p < 3; p++)
        for (int i = 0; i < 5; i++) begin
          cs = {8'hff, 8'h5a, 8'hff, 1'b0, (p == 0) ? 3'd0 : 3'd1, 3'b000, 1'b1};
          cd = (p == 1) ? 32'h0000_1F01 : 32'h0000_1F00;
          co = 32'(a) << (4 * p);
          bs = edge5[i];
          send("R5,R6");
        end

    // write mask merge (R7)
    cd = 32'h0000_1F00;
    for (int w = 0; w < 4; w++)
      for (int k = 0; k < 2; k++)
        for (int i = 0; i < 5; i++) begin
          cs = {8'hff, 8'h3c, wml[w], 1'b0, 3'd1, 3'b000, 1'b1};
          co = (k == 0) ? 32'h0000_0500 : 32'h0000_0200;
          bs = bsl[i];
          send("R7");
        end

    // depth test, depth write and colour enables (R8, R9, R10)
    cs = {8'hff, 8'h00, 8'hff, 8'h11};
    co = 32'h0000_0560;
    bs = 8'h40;
    for (int en = 0; en < 2; en++)
      for (int f = 0; f < 8; f++)
        for (int i = 0; i < 5; i++)
          for (int w = 0; w < 2; w++) begin
            cd = {19'h0, 1'(w), 4'((f + i + w) & 15), 1'b0, 3'(f), 3'b000, 1'(en)};
            fd = fdl[i]; bd = bdl[i];
            send("R8,R9,R10");
          end

    @(negedge clk); #1 in_valid = 1'b0;
    repeat (5) @(negedge clk);
    n_chk++;
    if (rd != wr) begin
      n_fail++;
      $display("FAIL R11 results received actual %0d expected %0d", rd, wr);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule